// File: doc/BRIEF.md
# Virtual to Physical Page Translator

This block sits beside the address generator of a DMA write engine. A channel's buffer is one contiguous range of virtual byte offsets, but the memory behind it is a scattered set of 4 kB physical pages. For each request the translator turns the channel's virtual offset into a physical bus address. The offset within the page passes through unchanged. The page part comes from a one-dword page-table entry that the block reads from host memory. No software runs per page.

Each channel keeps one cached mapping: the last virtual page number it resolved and the frame that page maps to. A request that stays in the cached page resolves in one cycle with no memory traffic. A request that enters another page triggers a single table read at base + 4 × page number, then refills the cache. A page number at or beyond the channel's programmed table length does not translate. It returns an error response and does not touch memory.

Requests and responses are valid/ready streams, and the block handles one request at a time. `req_ready` is high only while no request is in flight, so the requester is held off during a fetch and while a response waits for `rsp_ready`. The response must be held until it is taken. The table read port is a valid/ready request with an unconditioned one-cycle response pulse. The table base and length inputs are plain control levels and must be stable while their channel is in use.

Top module: `page_xlate`

## Requirements
- R1: The low 12 bits of `rsp_paddr` equal the low 12 bits of the accepted virtual offset, including offsets 0x000 and 0xFFF.
- R2: On a miss, the table read address is channel base + 4 × virtual page number, where the page number is the offset bits above bit 11. The response's upper 20 bits are bits 31:12 of the returned dword.
- R3: Exactly one table read is issued when the page number differs from the channel's cached one, or the channel has no cached entry. No read is issued when the page number matches.
- R4: On a cache hit or a length error, `rsp_valid` is high in the cycle after the request is accepted.
- R5: While a table read is pending, both `rsp_valid` and `req_ready` stay low.
- R6: A page number ≥ the channel's table length gives `rsp_err`=1 with `rsp_paddr`=0. It issues no table read and leaves that channel's cached mapping intact.
- R7: A fetch for one channel does not disturb the cached mapping of any other channel.
- R8: While `rsp_valid` is high and `rsp_ready` low, the response stays valid with unchanged address and error, and `req_ready` stays low.
- R9: Once `mem_req_valid` is raised, it and `mem_req_addr` stay unchanged until `mem_req_ready` is seen.
- R10: After reset, `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0, and every channel's cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base_i | input | NUM_CH*PA_W | Per-channel page-table base byte address, channel c at bits [c*PA_W +: PA_W] |
| tbl_len_i | input | NUM_CH*LEN_W | Per-channel number of table entries, channel c at bits [c*LEN_W +: LEN_W] |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_ch | input | CH_W | Requesting channel |
| req_voff | input | VA_W | Virtual byte offset in the channel buffer |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high together with rsp_valid |
| rsp_paddr | output | PA_W | Physical address (0 on error) |
| rsp_err | output | 1 | Page number beyond table length |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Table read request accepted |
| mem_req_addr | output | PA_W | Byte address of the table entry |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying the entry |
| mem_rsp_data | input | PA_W | Table entry dword |

## Verification
A cached page number or valid bit that goes wrong appears at the ports within one transaction. It shows up as a table read where none belongs, or as a missing read that leaves the response one cycle after acceptance with a stale frame. A cache that is overwritten under the wrong channel index shows up on the next access of the other channel, so the stimulus interleaves channels and revisits earlier pages. A state machine that leaves its wait state early raises `rsp_valid` or `req_ready` while the table read is still open, and that can be seen on the same cycle.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int PAGE_BITS = 12;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_MISS,
    XS_RESP
  } xl_state_e;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_REQ,
    WK_WAIT
  } walk_state_e;
endpackage

// File: rtl/pgx_cache.sv
module pgx_cache #(
  parameter int NUM_CH  = 4,
  parameter int CH_W    = 2,
  parameter int VPN_W   = 10,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CH_W-1:0]    rd_ch,
  input  logic [VPN_W-1:0]   rd_vpn,
  output logic               rd_hit,
  output logic [FRAME_W-1:0] rd_frame,
  input  logic               wr_en,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [FRAME_W-1:0] wr_frame
);
  logic               valid_q [NUM_CH];
  logic [VPN_W-1:0]   vpn_q   [NUM_CH];
  logic [FRAME_W-1:0] frame_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        vpn_q[g]   <= '0;
        frame_q[g] <= '0;
      end else if (wr_en && wr_ch == CH_W'(g)) begin
        valid_q[g] <= 1'b1;
        vpn_q[g]   <= wr_vpn;
        frame_q[g] <= wr_frame;
      end
    end
  end

  assign rd_hit   = valid_q[rd_ch] && (vpn_q[rd_ch] == rd_vpn);
  assign rd_frame = frame_q[rd_ch];
endmodule

// File: rtl/pgx_walker.sv
module pgx_walker #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PA_W-1:0] start_addr,
  output logic            done,
  output logic [PA_W-1:0] entry,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [PA_W-1:0] mem_rsp_data
);
  import pgx_pkg::*;

  walk_state_e     st_q;
  logic [PA_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      addr_q <= '0;
    end else begin
      case (st_q)
        WK_IDLE: if (start) begin
          st_q   <= WK_REQ;
          addr_q <= start_addr;
        end
        WK_REQ:  if (mem_req_ready) st_q <= WK_WAIT;
        WK_WAIT: if (mem_rsp_valid) st_q <= WK_IDLE;
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == WK_REQ);
  assign mem_req_addr  = addr_q;
  assign done          = (st_q == WK_WAIT) && mem_rsp_valid;
  assign entry         = mem_rsp_data;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int NUM_CH = 4,
  parameter int VA_W   = 22,
  parameter int PA_W   = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int VPN_W = VA_W - pgx_pkg::PAGE_BITS,
  localparam int LEN_W = VPN_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH*PA_W-1:0] tbl_base_i,
  input  logic [NUM_CH*LEN_W-1:0] tbl_len_i,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [CH_W-1:0]        req_ch,
  input  logic [VA_W-1:0]        req_voff,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic                   rsp_err,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [PA_W-1:0]        mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PA_W-1:0]        mem_rsp_data
);
  import pgx_pkg::*;
  localparam int FRAME_W = PA_W - PAGE_BITS;

  logic [PA_W-1:0]  base_a [NUM_CH];
  logic [LEN_W-1:0] len_a  [NUM_CH];
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
    assign base_a[g] = tbl_base_i[g*PA_W +: PA_W];
    assign len_a[g]  = tbl_len_i[g*LEN_W +: LEN_W];
  end

  xl_state_e          st_q;
  logic [CH_W-1:0]    cur_ch_q;
  logic [VPN_W-1:0]   cur_vpn_q;
  logic [PAGE_BITS-1:0] cur_off_q;
  logic [PA_W-1:0]    paddr_q;
  logic               err_q;

  logic [VPN_W-1:0]   in_vpn;
  logic               in_oob, hit, accept, walk_start, walk_done;
  logic [FRAME_W-1:0] hit_frame;
  logic [PA_W-1:0]    walk_addr, walk_entry;

  assign in_vpn     = req_voff[VA_W-1:PAGE_BITS];
  assign in_oob     = {1'b0, in_vpn} >= len_a[req_ch];
  assign req_ready  = (st_q == XS_IDLE);
  assign accept     = req_valid && req_ready;
  assign walk_start = accept && !in_oob && !hit;
  assign walk_addr  = base_a[req_ch] + {{(PA_W-VPN_W-2){1'b0}}, in_vpn, 2'b00};

  pgx_cache #(.NUM_CH(NUM_CH), .CH_W(CH_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_ch    (req_ch),
    .rd_vpn   (in_vpn),
    .rd_hit   (hit),
    .rd_frame (hit_frame),
    .wr_en    ((st_q == XS_MISS) && walk_done),
    .wr_ch    (cur_ch_q),
    .wr_vpn   (cur_vpn_q),
    .wr_frame (walk_entry[PA_W-1:PAGE_BITS])
  );

  pgx_walker #(.PA_W(PA_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (walk_start),
    .start_addr    (walk_addr),
    .done          (walk_done),
    .entry         (walk_entry),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= XS_IDLE;
      cur_ch_q  <= '0;
      cur_vpn_q <= '0;
      cur_off_q <= '0;
      paddr_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      case (st_q)
        XS_IDLE: if (accept) begin
          cur_ch_q  <= req_ch;
          cur_vpn_q <= in_vpn;
          cur_off_q <= req_voff[PAGE_BITS-1:0];
          if (in_oob) begin
            err_q   <= 1'b1;
            paddr_q <= '0;
            st_q    <= XS_RESP;
          end else if (hit) begin
            err_q   <= 1'b0;
            paddr_q <= {hit_frame, req_voff[PAGE_BITS-1:0]};
            st_q    <= XS_RESP;
          end else begin
            st_q    <= XS_MISS;
          end
        end
        XS_MISS: if (walk_done) begin
          err_q   <= 1'b0;
          paddr_q <= {walk_entry[PA_W-1:PAGE_BITS], cur_off_q};
          st_q    <= XS_RESP;
        end
        XS_RESP: if (rsp_ready) st_q <= XS_IDLE;
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  assign rsp_valid = (st_q == XS_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_err   = err_q;

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_err));
  // R5
  fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid && !req_ready);
  // R6
  err_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> !mem_req_valid && (rsp_paddr == '0));
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !rsp_err |-> rsp_paddr[PAGE_BITS-1:0] == cur_off_q);
endmodule

// File: tb/page_xlate_bench.sv
module page_xlate_bench;
  localparam int NUM_CH = 4;
  localparam int VA_W   = 22;
  localparam int PA_W   = 32;
  localparam int CH_W   = 2;
  localparam int VPN_W  = VA_W - 12;
  localparam int LEN_W  = VPN_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NUM_CH*PA_W-1:0]  tbl_base_i;
  logic [NUM_CH*LEN_W-1:0] tbl_len_i;
  logic req_valid = 1'b0, req_ready;
  logic [CH_W-1:0] req_ch = '0;
  logic [VA_W-1:0] req_voff = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_err;
  logic [PA_W-1:0] rsp_paddr;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [PA_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [PA_W-1:0] mem_rsp_data = '0;

  page_xlate #(.NUM_CH(NUM_CH), .VA_W(VA_W), .PA_W(PA_W)) u_page_xlate (
    .clk(clk), .rst_n(rst_n), .tbl_base_i(tbl_base_i), .tbl_len_i(tbl_len_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch), .req_voff(req_voff),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0, n_bad = 0;
  int nreq = 0;
  logic [PA_W-1:0] last_maddr = '0;
  bit   mvalid [NUM_CH];
  logic [VPN_W-1:0] mvpn [NUM_CH];

  function automatic logic [31:0] entry_fn(logic [31:0] a);
    logic [31:0] x;
    x = a * 32'h9E3779B1;
    return x ^ (x >> 15) ^ 32'h5A00_0000;
  endfunction

  function automatic logic [31:0] base_of(int c);
    return 32'h1000_0000 + 32'(c) * 32'h0010_0000;
  endfunction

  function automatic int len_of(int c);
    case (c)
      0: return 16;
      1: return 40;
      2: return 300;
      default: return 1024;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // table memory model: ready and handshake decided at the same negedge
  int lat = 0;
  bit busy = 0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (busy) begin
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = entry_fn(last_maddr);
        busy = 0;
      end else lat--;
      mem_req_ready = 1'b0;
    end else begin
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready && rst_n) begin
        last_maddr = mem_req_addr;
        nreq++;
        busy = 1;
        lat = $urandom % 4;
      end
    end
  end

  task automatic xact(int ch, logic [VA_W-1:0] voff);
    logic [VPN_W-1:0] vpn;
    bit exp_err, exp_miss;
    int n0, cyc, hold;
    logic [PA_W-1:0] p0, exp_pa;
    vpn = voff[VA_W-1:12];
    exp_err  = int'(vpn) >= len_of(ch);
    exp_miss = !exp_err && (!mvalid[ch] || mvpn[ch] != vpn);
    n0 = nreq;
    @(negedge clk);
    req_valid = 1'b1; req_ch = CH_W'(ch); req_voff = voff;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 60) begin
      check(!req_ready, "R5 req_ready during fetch", 64'(req_ready), 0);
      @(negedge clk);
      cyc++;
    end
    if (!exp_miss) check(cyc == 1, "R4 hit/error latency", 64'(cyc), 1);
    else           check(cyc > 1, "R5 rsp held low during fetch", 64'(cyc), 2);
    check(nreq - n0 == (exp_miss ? 1 : 0), exp_err ? "R6 no read on error" : "R3 read count",
          64'(nreq - n0), 64'(exp_miss));
    if (exp_miss)
      check(last_maddr == base_of(ch) + 32'(vpn) * 4, "R2 entry address",
            64'(last_maddr), 64'(base_of(ch) + 32'(vpn) * 4));
    exp_pa = exp_err ? '0 : {entry_fn(base_of(ch) + 32'(vpn) * 4)[31:12], voff[11:0]};
    check(rsp_err == exp_err, "R6 error flag", 64'(rsp_err), 64'(exp_err));
    check(rsp_paddr == exp_pa, exp_err ? "R6 zero address" : "R1 R2 R7 paddr",
          64'(rsp_paddr), 64'(exp_pa));
    hold = $urandom % 3;
    p0 = rsp_paddr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == p0 && !req_ready, "R8 response hold",
            64'(rsp_paddr), 64'(p0));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (exp_miss) begin mvalid[ch] = 1; mvpn[ch] = vpn; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < NUM_CH; c++) begin
      tbl_base_i[c*PA_W +: PA_W]   = base_of(c);
      tbl_len_i[c*LEN_W +: LEN_W]  = LEN_W'(len_of(c));
      mvalid[c] = 0; mvpn[c] = '0;
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready == 1, "R10 req_ready", 64'(req_ready), 1);
    check(rsp_valid == 0, "R10 rsp_valid", 64'(rsp_valid), 0);
    check(mem_req_valid == 0, "R10 mem_req_valid", 64'(mem_req_valid), 0);
    rst_n = 1'b1;
    // directed corners
    xact(0, {10'd3, 12'h000});   // R10 first access misses, R1 offset 0
    xact(0, {10'd3, 12'hFFF});   // R3 hit, R1 offset 0xFFF
    xact(0, {10'd4, 12'h010});   // R3 new page
    xact(1, {10'd7, 12'h123});   // R7 other channel
    xact(0, {10'd4, 12'h456});   // R7 ch0 still cached
    xact(0, {10'd16, 12'h001});  // R6 first out-of-range page
    xact(0, {10'd4, 12'h789});   // R6 cache intact
    xact(0, {10'd15, 12'hABC});  // R6 last valid page
    xact(3, {10'd1023, 12'h004});// full-range page
    // random phase
    for (int t = 0; t < 400; t++) begin
      int c;
      logic [VPN_W-1:0] v;
      c = $urandom % NUM_CH;
      if ($urandom % 2) v = mvpn[c];
      else v = VPN_W'($urandom % (len_of(c) + 4));
      xact(c, {v, 12'($urandom)});
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule